// File: doc/BRIEF.md
# Modem Control and Status Register Pair with Loopback

This block holds the modem control register and the modem status register of a 16550-style serial port. Software writes the control register and reads both registers over a simple register bus with separate write and read address ports. The status register has two halves: the upper four bits show the current state of the four modem status lines, and the lower four bits are sticky change indicators (deltas) that record what changed since the status register was last read.

In loopback mode the four control outputs are routed back onto the four status lines. In normal mode the status lines take fixed values, so that carrier detect and data-set-ready always appear asserted. Delta bits are computed each time the control register is written, by comparing the status lines before and after the write. A single registered flag tells the interrupt logic that at least one delta bit is set.

Top module: `modem_status_unit`

## Requirements
- R1: A control write (write address MCR_ADDR, default 4) stores write-data bits 4:0: bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2, bit4 loopback. Reading the control register returns those five bits with bits 7:5 always zero.
- R2: With loopback set, status bits are driven as: bit4 (CTS) from RTS, bit5 (DSR) from DTR, bit6 (RI) from OUT1, bit7 (DCD) from OUT2.
- R3: With loopback clear, status bits 7:4 read 4'b1010: DCD and DSR asserted, RI and CTS deasserted.
- R4: On a control write, a change of CTS sets delta bit0, a change of DSR sets delta bit1, and a change of DCD sets delta bit3.
- R5: Delta bit2 (trailing-edge ring) is set only when RI goes from 1 to 0 on a control write; a 0-to-1 change of RI leaves it unchanged.
- R6: Delta bits already set stay set across control writes and idle cycles; the status half always takes the newly computed line values.
- R7: A read of the status register (read address MSR_ADDR, default 6) returns the status value held before that clock edge on rd_data in the following cycle, and clears all four delta bits.
- R8: Writes to the status address, or to any address other than the control address, change neither register.
- R9: modem_chg is high exactly when at least one delta bit is set, updated in the same cycle as the delta bits.
- R10: After reset the control register is 0, the status register is 8'hA0, modem_chg is 0 and rd_data is 0.
- R11: When a control write and a status read fall in the same cycle, the read returns the value from before the write, and the delta bits produced by that write survive the read's clear.
- R12: rd_data is registered: it changes only in the cycle after a read, and a read of any address other than the two register addresses returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data |
| modem_chg | output | 1 | Modem-status change pending flag |

## Verification
The clear-on-read of the status register and the delta update from a control write can land on the same clock edge, since the bus has independent read and write addresses. The bench provokes this with directed cycles that flip loopback lines while reading the status register, and the random phase drives both strobes together often. It judges the result by checking that the returned value predates the write and that a follow-up status read still shows the deltas that write produced, with modem_chg high in between.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int DATA_W   = 8;
  localparam int CTL_W    = 5;
  localparam int LINE_W   = 4;
  localparam int LOOP_BIT = 4;

  // Status line nibble in register bit order (bit7 down to bit4)
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } line_t;

  localparam line_t LINES_IDLE = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b0};
endpackage

// File: rtl/mdm_line_map.sv
module mdm_line_map
  import mdm_pkg::*;
(
  input  logic [CTL_W-1:0] ctl,
  output line_t            lines
);
  always_comb begin
    if (ctl[LOOP_BIT]) begin
      lines.cts = ctl[1];
      lines.dsr = ctl[0];
      lines.ri  = ctl[2];
      lines.dcd = ctl[3];
    end else begin
      lines = LINES_IDLE;
    end
  end
endmodule

// File: rtl/mdm_delta_gen.sv
module mdm_delta_gen
  import mdm_pkg::*;
(
  input  logic              enable,
  input  line_t             prev,
  input  line_t             cur,
  output logic [LINE_W-1:0] set
);
  always_comb begin
    set = '0;
    if (enable) begin
      set[0] = prev.cts ^ cur.cts;
      set[1] = prev.dsr ^ cur.dsr;
      set[2] = prev.ri & ~cur.ri;
      set[3] = prev.dcd ^ cur.dcd;
    end
  end
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import mdm_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int MCR_ADDR = 4,
  parameter int MSR_ADDR = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              modem_chg
);
  localparam logic [ADDR_W-1:0] CTL_SEL = ADDR_W'(MCR_ADDR);
  localparam logic [ADDR_W-1:0] STS_SEL = ADDR_W'(MSR_ADDR);

  logic [CTL_W-1:0]  mcr_q, mcr_d;
  line_t             line_q, line_d;
  logic [LINE_W-1:0] delta_q, delta_d, delta_set;
  logic [DATA_W-1:0] msr_q, rd_q, rd_sel;
  logic              chg_q;
  logic              ctl_write, sts_read;

  assign ctl_write = wr_en && (wr_addr == CTL_SEL);
  assign sts_read  = rd_en && (rd_addr == STS_SEL);
  assign msr_q     = {line_q, delta_q};

  // Reset forces the control value to zero so the line map yields reset lines.
  always_comb begin
    if (rst)            mcr_d = '0;
    else if (ctl_write) mcr_d = wr_data[CTL_W-1:0];
    else                mcr_d = mcr_q;
  end

  mdm_line_map u_map (
    .ctl   (mcr_d),
    .lines (line_d)
  );

  mdm_delta_gen u_delta (
    .enable (ctl_write && !rst),
    .prev   (line_q),
    .cur    (line_d),
    .set    (delta_set)
  );

  always_comb begin
    if (rst) delta_d = '0;
    else     delta_d = (sts_read ? '0 : delta_q) | delta_set;
  end

  always_comb begin
    if (rd_addr == CTL_SEL)      rd_sel = {{(DATA_W-CTL_W){1'b0}}, mcr_q};
    else if (rd_addr == STS_SEL) rd_sel = msr_q;
    else                         rd_sel = '0;
  end

  always_ff @(posedge clk) begin
    mcr_q   <= mcr_d;
    line_q  <= line_d;
    delta_q <= delta_d;
    chg_q   <= |delta_d;
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_sel;
  end

  assign rd_data   = rd_q;
  assign modem_chg = chg_q;
endmodule

// File: rtl/modem_status_unit_chk.sv
module modem_status_unit_chk #(
  parameter int ADDR_W   = 3,
  parameter int MCR_ADDR = 4,
  parameter int MSR_ADDR = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic              modem_chg,
  input logic [4:0]        mcr_q,
  input logic [7:0]        msr_q
);
  logic ctl_w, sts_r, ctl_r;
  assign ctl_w = wr_en && (wr_addr == ADDR_W'(MCR_ADDR));
  assign sts_r = rd_en && (rd_addr == ADDR_W'(MSR_ADDR));
  assign ctl_r = rd_en && (rd_addr == ADDR_W'(MCR_ADDR));

  p_ctl_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    ctl_r |=> rd_data[7:5] == 3'b000);

  p_loop_map_r2: assert property (@(posedge clk) disable iff (rst)
    mcr_q[4] |-> msr_q[7:4] == {mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1]});

  p_idle_lines_r3: assert property (@(posedge clk) disable iff (rst)
    !mcr_q[4] |-> msr_q[7:4] == 4'b1010);

  p_no_new_delta_r5: assert property (@(posedge clk) disable iff (rst)
    !ctl_w |=> (msr_q[3:0] & ~$past(msr_q[3:0])) == 4'b0000);

  p_delta_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !sts_r |=> (msr_q[3:0] & $past(msr_q[3:0])) == $past(msr_q[3:0]));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (sts_r && !ctl_w) |=> msr_q[3:0] == 4'b0000);

  p_ignored_write_r8: assert property (@(posedge clk) disable iff (rst)
    (!ctl_w && !sts_r) |=> ($stable(msr_q) && $stable(mcr_q)));

  p_chg_flag_r9: assert property (@(posedge clk) disable iff (rst)
    modem_chg == (msr_q[3:0] != 4'b0000));
endmodule

bind modem_status_unit modem_status_unit_chk #(
  .ADDR_W(ADDR_W), .MCR_ADDR(MCR_ADDR), .MSR_ADDR(MSR_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .modem_chg(modem_chg), .mcr_q(mcr_q), .msr_q(msr_q)
);

// File: tb/sim_modem_status_unit.sv
`timescale 1ns/1ps
module sim_modem_status_unit;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_CTL = 3'd4;
  localparam logic [AW-1:0] A_STS = 3'd6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    rd_data;
  logic          modem_chg;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [4:0] m_ctl;
  logic [7:0] m_sts;

  always #5 clk = ~clk;

  modem_status_unit #(.ADDR_W(AW), .MCR_ADDR(4), .MSR_ADDR(6)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .modem_chg(modem_chg)
  );

  function automatic logic [3:0] lines_of(input logic [4:0] c);
    if (c[4]) return {c[3], c[2], c[0], c[1]};
    return 4'b1010;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one bus cycle from a negedge; compare results at the next negedge.
  task automatic cyc(input bit w, input logic [AW-1:0] wa, input logic [7:0] wd,
                     input bit r, input logic [AW-1:0] ra, input string req);
    logic [7:0] exp_rd;
    logic [3:0] nl, ol, set;
    exp_rd = rd_data;
    if (r) begin
      if (ra == A_CTL)      exp_rd = {3'b000, m_ctl};
      else if (ra == A_STS) exp_rd = m_sts;
      else                  exp_rd = 8'h00;
    end
    wr_en = w; wr_addr = wa; wr_data = wd; rd_en = r; rd_addr = ra;
    set = 4'b0000;
    ol = m_sts[7:4];
    nl = ol;
    if (w && wa == A_CTL) begin
      m_ctl = wd[4:0];
      nl = lines_of(m_ctl);
      set[0] = ol[0] ^ nl[0];
      set[1] = ol[1] ^ nl[1];
      set[2] = ol[2] & ~nl[2];
      set[3] = ol[3] ^ nl[3];
    end
    m_sts[3:0] = ((r && ra == A_STS) ? 4'b0000 : m_sts[3:0]) | set;
    m_sts[7:4] = nl;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check({req, " rd_data"}, rd_data, exp_rd);
    check({req, " R9 flag"}, {7'b0, modem_chg}, {7'b0, |m_sts[3:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    m_ctl = 5'b0; m_sts = 8'hA0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    check("R10 rd_data", rd_data, 8'h00);
    check("R10 flag", {7'b0, modem_chg}, 8'h00);
    cyc(0, 0, 0, 1, A_STS, "R10 msr");
    cyc(0, 0, 0, 1, A_CTL, "R10 mcr");
    // R1 upper bits dropped
    cyc(1, A_CTL, 8'hE3, 0, 0, "R1 write");
    cyc(0, 0, 0, 1, A_CTL, "R1 readback");
    cyc(1, A_CTL, 8'h00, 0, 0, "R1 clear");
    // R3 normal mode status fixed
    cyc(0, 0, 0, 1, A_STS, "R3 normal");
    // R2 loopback, all outputs low: CTS unchanged, DSR and DCD fall -> R4 deltas
    cyc(1, A_CTL, 8'h10, 0, 0, "R2 loop enter");
    cyc(0, 0, 0, 1, A_STS, "R4 deltas");
    cyc(0, 0, 0, 1, A_STS, "R7 cleared");
    // R5 RI rising: no TERI
    cyc(1, A_CTL, 8'h14, 0, 0, "R5 ri rise");
    cyc(0, 0, 0, 1, A_STS, "R5 no teri");
    // R5 RI falling: TERI set
    cyc(1, A_CTL, 8'h10, 0, 0, "R5 ri fall");
    cyc(0, 0, 0, 1, A_STS, "R5 teri");
    // R2 each mapping; R6 sticky across writes
    cyc(1, A_CTL, 8'h12, 0, 0, "R2 rts");
    cyc(1, A_CTL, 8'h13, 0, 0, "R2 dtr");
    cyc(1, A_CTL, 8'h1B, 0, 0, "R6 sticky");
    cyc(0, 0, 0, 0, 0, "R6 idle");
    cyc(0, 0, 0, 1, A_STS, "R6 read");
    // R8 ignored writes
    cyc(1, A_STS, 8'hFF, 0, 0, "R8 sts write");
    cyc(1, 3'd2, 8'h00, 0, 0, "R8 other write");
    cyc(0, 0, 0, 1, A_STS, "R8 sts after");
    cyc(0, 0, 0, 1, A_CTL, "R8 ctl after");
    // R12 unused address and hold
    cyc(0, 0, 0, 1, 3'd1, "R12 unused");
    cyc(0, 0, 0, 0, A_STS, "R12 hold");
    // R11 simultaneous write and read
    cyc(1, A_CTL, 8'h14, 1, A_STS, "R11 same cycle");
    cyc(0, 0, 0, 1, A_STS, "R11 deltas kept");
    // Random mix
    for (int i = 0; i < 400; i++) begin
      automatic int p = $urandom_range(0, 9);
      automatic logic [AW-1:0] wa = (p < 6) ? A_CTL : ((p < 8) ? A_STS : AW'($urandom));
      automatic logic [AW-1:0] ra = (p % 3 == 0) ? A_CTL : ((p % 3 == 1) ? A_STS : AW'($urandom));
      cyc($urandom_range(0, 1) == 1, wa, 8'($urandom), $urandom_range(0, 1) == 1, ra,
          "R4 R11 random");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule